// File: doc/BRIEF.md
# Dual-Channel Datapath Self-Test Controller

This block exercises the digital datapath of two converter channels without any analog input. On command it replaces the converter data entering each selected channel's datapath with the output of a 10-bit pseudorandom generator. The injection lasts a fixed number of cycles and then ends by itself. While the run is in progress, the datapath output stays connected, so the pseudorandom stream can be watched on the output pins.

Each selected channel's datapath output is folded into a 16-bit multiple-input signature register. When the run completes, the result is placed in two byte-wide readable registers. A single selected channel gives its own signature. Two selected channels give the bitwise XOR of both signatures. In this block the datapath is a single registered stage.

A byte-wide register port carries all of the control:
- channel select;
- a start bit;
- a choice between reseeding the generator and resuming it from where the last run left it;
- a test bit that pins the generator to its seed.

Top module: `dp_selftest`

## Requirements
- R1: While a run injects, each selected channel's datapath input is its own pseudorandom generator. An unselected channel keeps passing its converter input. The datapath output follows its input with one cycle of latency.
- R2: Each generator is a 10-bit LFSR with seed 10'h3FF. One step shifts the state left by one and makes the new bit 0 equal to bit 9 XOR bit 6. The first injected value is the state at the start of the run, and the state steps once per injected cycle of its channel.
- R3: A run is started by a write of 1 to bit 3 of the control register. Injection lasts exactly 512 cycles, after which the outputs return to converter data. `busy_o` is high from the write edge for 514 cycles. `done_o` clears at start and goes high when `busy_o` falls.
- R4: Each channel's signature register is 16 bits wide and is cleared at start. It takes one update per datapath output of the run: next = {s[14:0],0} XOR (s[15] ? 16'h1021 : 0) XOR zero-extended data.
- R5: The result is read at address 0x24 (low byte) and 0x25 (high byte). With one channel selected, the result is that channel's signature.
- R6: With both channels selected, the result is the XOR of the two signatures. With none selected, it is 0.
- R7: The control register is at address 0x0E:
  - bit 0 selects channel A;
  - bit 1 selects channel B;
  - bit 2 set resumes each generator from its last state, and bit 2 clear reseeds it at start;
  - bit 3 is start and reads back as 0.
- R8: Bit 4 of the test register at 0x0D holds both generators at their seed, so a selected channel outputs 10'h3FF for the whole run.
- R9: A control register write while `busy_o` is high is ignored. It neither restarts the run nor changes the configuration or the result.
- R10: After reset, `busy_o`, `done_o`, the result registers, the control register and both datapath outputs are 0.
- R11: `rdata_o` returns the register addressed by `addr_i` one cycle later. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for writes and reads |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data |
| adc_a_i | input | 10 | Converter data, channel A |
| adc_b_i | input | 10 | Converter data, channel B |
| dout_a_o | output | 10 | Datapath output, channel A |
| dout_b_o | output | 10 | Datapath output, channel B |
| busy_o | output | 1 | Self-test in progress |
| done_o | output | 1 | Self-test finished since last start |

## Verification
The sweep runs every channel-select value with reseeding:
- A alone and B alone give matching signatures, which tells a crossed or shared generator apart.
- Both channels from a fresh seed must give 0.
- No channel selected must also give 0.

Resumed runs follow a single-channel run. Here the two generators hold different states, so the combined result exposes a generator that reseeds wrongly or steps while its channel is idle. A held-generator run drives a constant word and separates hold from reseed. A run with a control write injected midway shows whether busy-time writes leak into the run length, the configuration or the result.

// File: rtl/dpst_pkg.sv
package dpst_pkg;
  localparam logic [7:0] ADDR_TEST   = 8'h0D;
  localparam logic [7:0] ADDR_CTRL   = 8'h0E;
  localparam logic [7:0] ADDR_SIG_LO = 8'h24;
  localparam logic [7:0] ADDR_SIG_HI = 8'h25;
  localparam int unsigned CTRL_SEL_A = 0;
  localparam int unsigned CTRL_SEL_B = 1;
  localparam int unsigned CTRL_KEEP  = 2;
  localparam int unsigned CTRL_GO    = 3;
  localparam int unsigned TEST_HOLD  = 4;
endpackage

// File: rtl/dpst_lfsr.sv
module dpst_lfsr #(
  parameter int unsigned W    = 10,
  parameter int unsigned TAP  = 6,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         reseed,
  input  logic         adv,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst || hold || reseed) state <= SEED;
    else if (adv)              state <= {state[W-2:0], state[W-1] ^ state[TAP]};
  end

  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  p_lfsr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    hold |=> state == SEED);
endmodule

// File: rtl/dpst_misr.sv
module dpst_misr #(
  parameter int unsigned DW   = 10,
  parameter int unsigned SW   = 16,
  parameter logic [SW-1:0] POLY = 16'h1021
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [SW-1:0] sig
);
  logic [SW-1:0] nxt;

  always_comb begin
    nxt = {sig[SW-2:0], 1'b0} ^ {{(SW-DW){1'b0}}, d};
    if (sig[SW-1]) nxt = nxt ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) sig <= '0;
    else if (en)    sig <= nxt;
  end

  p_misr_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> sig == '0);
  p_misr_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(sig));
endmodule

// File: rtl/dpst_seq.sv
module dpst_seq #(
  parameter int unsigned RUN_LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic inj,
  output logic fin,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(RUN_LEN);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt;
  logic          cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      inj <= 1'b0; cap <= 1'b0; fin <= 1'b0;
      busy <= 1'b0; done <= 1'b0; cnt <= '0;
    end else begin
      cap <= inj;
      fin <= cap & ~inj;
      if (go) begin
        inj  <= 1'b1;
        cnt  <= '0;
        busy <= 1'b1;
        done <= 1'b0;
      end else begin
        if (inj) begin
          if (cnt == LAST) inj <= 1'b0;
          else             cnt <= cnt + 1'b1;
        end
        if (fin) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_run_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(inj) |-> $past(cnt) == LAST);
  p_busy_done_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  p_inj_busy_r3: assert property (@(posedge clk) disable iff (rst)
    inj |-> busy);
endmodule

// File: rtl/dpst_chan.sv
module dpst_chan #(
  parameter int unsigned DW   = 10,
  parameter int unsigned SW   = 16,
  parameter int unsigned TAP  = 6,
  parameter logic [DW-1:0] SEED = '1,
  parameter logic [SW-1:0] POLY = 16'h1021
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          inj,
  input  logic          go,
  input  logic          keep,
  input  logic          hold,
  input  logic [DW-1:0] adc_d,
  output logic [DW-1:0] dout,
  output logic [SW-1:0] sig
);
  logic          inj_c, cap_c;
  logic [DW-1:0] pn, din;

  assign inj_c = inj & sel;

  dpst_lfsr #(.W(DW), .TAP(TAP), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .hold(hold), .reseed(go & ~keep),
    .adv(inj_c), .state(pn)
  );

  assign din = inj_c ? pn : adc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      cap_c <= 1'b0;
    end else begin
      dout  <= din;
      cap_c <= inj_c;
    end
  end

  dpst_misr #(.DW(DW), .SW(SW), .POLY(POLY)) u_misr (
    .clk(clk), .rst(rst), .clr(go), .en(cap_c), .d(dout), .sig(sig)
  );

  p_pass_r1: assert property (@(posedge clk) disable iff (rst)
    !inj_c |=> dout == $past(adc_d));
  p_inject_r1: assert property (@(posedge clk) disable iff (rst)
    inj_c |=> dout == $past(pn));
endmodule

// File: rtl/dp_selftest.sv
module dp_selftest
  import dpst_pkg::*;
#(
  parameter int unsigned DW      = 10,
  parameter int unsigned SW      = 16,
  parameter int unsigned RUN_LEN = 512,
  parameter int unsigned TAP     = 6,
  parameter logic [DW-1:0] SEED  = 10'h3FF,
  parameter logic [SW-1:0] POLY  = 16'h1021
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [DW-1:0] adc_a_i,
  input  logic [DW-1:0] adc_b_i,
  output logic [DW-1:0] dout_a_o,
  output logic [DW-1:0] dout_b_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned NCH = 2;

  logic [2:0]    ctrl_q;
  logic          hold_q;
  logic [SW-1:0] sig_q, sig_c;
  logic          ctrl_wr, go, inj, fin;
  logic [DW-1:0] adc_v  [NCH];
  logic [DW-1:0] dout_v [NCH];
  logic [SW-1:0] misr_v [NCH];
  wire           unused_wbits = ^{wdata_i[7:5], wdata_i[3:0]};

  assign ctrl_wr = wr_i && (addr_i == ADDR_CTRL) && !busy_o;
  assign go      = ctrl_wr && wdata_i[CTRL_GO];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      hold_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata_i[2:0];
      if (wr_i && addr_i == ADDR_TEST) hold_q <= wdata_i[TEST_HOLD];
    end
  end

  dpst_seq #(.RUN_LEN(RUN_LEN)) u_seq (
    .clk(clk), .rst(rst), .go(go), .inj(inj), .fin(fin),
    .busy(busy_o), .done(done_o)
  );

  assign adc_v[0] = adc_a_i;
  assign adc_v[1] = adc_b_i;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dpst_chan #(.DW(DW), .SW(SW), .TAP(TAP), .SEED(SEED), .POLY(POLY)) u_chan (
      .clk(clk), .rst(rst), .sel(ctrl_q[c]), .inj(inj), .go(go),
      .keep(wdata_i[CTRL_KEEP]), .hold(hold_q), .adc_d(adc_v[c]),
      .dout(dout_v[c]), .sig(misr_v[c])
    );
  end

  assign dout_a_o = dout_v[0];
  assign dout_b_o = dout_v[1];

  always_comb begin
    sig_c = '0;
    for (int c = 0; c < NCH; c++)
      if (ctrl_q[c]) sig_c = sig_c ^ misr_v[c];
  end

  always_ff @(posedge clk) begin
    if (rst)      sig_q <= '0;
    else if (fin) sig_q <= sig_c;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (addr_i)
        ADDR_CTRL:   rdata_o <= {5'b0, ctrl_q};
        ADDR_TEST:   rdata_o <= {3'b0, hold_q, 4'b0};
        ADDR_SIG_LO: rdata_o <= sig_q[7:0];
        ADDR_SIG_HI: rdata_o <= sig_q[15:8];
        default:     rdata_o <= 8'h00;
      endcase
    end
  end

  p_ctrl_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && wr_i && addr_i == ADDR_CTRL) |=> $stable(ctrl_q));
  p_result_steady_r5: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(sig_q));
  p_result_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(fin));
endmodule

// File: tb/test_dp_selftest.sv
module test_dp_selftest;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 512;
  localparam logic [9:0] SEED = 10'h3FF;

  logic clk = 1'b0, rst = 1'b1, wr = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [9:0] adc_a = 10'h155, adc_b = 10'h2AA;
  logic [7:0] rdata;
  logic [9:0] dout_a, dout_b;
  logic busy, done;

  int checks = 0, errors = 0;
  logic [9:0] mdl_a = SEED, mdl_b = SEED;
  logic mdl_hold = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_selftest i_dp_selftest (
    .clk(clk), .rst(rst), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .adc_a_i(adc_a), .adc_b_i(adc_b),
    .dout_a_o(dout_a), .dout_b_o(dout_b), .busy_o(busy), .done_o(done)
  );

  function automatic logic [9:0] lfsr_nx(logic [9:0] s);
    return {s[8:0], s[9] ^ s[6]};
  endfunction

  function automatic logic [15:0] misr_nx(logic [15:0] m, logic [9:0] d);
    logic [15:0] n;
    n = {m[14:0], 1'b0} ^ {6'b0, d};
    if (m[15]) n = n ^ 16'h1021;
    return n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic run_case(logic [1:0] sel, logic keep, logic poke, string name);
    logic [9:0] pa, pb;
    logic [15:0] ma, mb, exp_sig;
    logic [7:0] lo, hi, cr;
    ma = '0; mb = '0;
    if (mdl_hold) begin pa = SEED; pb = SEED; end
    else begin pa = keep ? mdl_a : SEED; pb = keep ? mdl_b : SEED; end
    reg_wr(8'h0E, {4'b0000, 1'b1, keep, sel} << 0 | 8'h00);
    chk("R3", 32'(busy), 32'd1, {name, " busy after start"});
    chk("R3", 32'(done), 32'd0, {name, " done cleared at start"});
    for (int k = 0; k < RUN; k++) begin
      @(negedge clk);
      wr = 1'b0;
      chk("R1", 32'(dout_a), 32'(sel[0] ? pa : adc_a), {name, " chan A stream"});
      chk("R1", 32'(dout_b), 32'(sel[1] ? pb : adc_b), {name, " chan B stream"});
      if (poke && k == 100) begin
        wr = 1'b1; addr = 8'h0E; wdata = 8'h0F; // R9: busy-time write
      end
      if (sel[0]) begin ma = misr_nx(ma, pa); if (!mdl_hold) pa = lfsr_nx(pa); end
      if (sel[1]) begin mb = misr_nx(mb, pb); if (!mdl_hold) pb = lfsr_nx(pb); end
    end
    chk("R3", 32'(busy), 32'd1, {name, " busy on last injected cycle"});
    @(negedge clk);
    chk("R3", 32'(dout_a), 32'(adc_a), {name, " A back to converter after 512"});
    chk("R3", 32'(dout_b), 32'(adc_b), {name, " B back to converter after 512"});
    chk("R3", 32'(busy), 32'd1, {name, " busy through final capture"});
    @(negedge clk);
    chk("R3", 32'(busy), 32'd0, {name, " busy falls"});
    chk("R3", 32'(done), 32'd1, {name, " done set"});
    if (mdl_hold) begin mdl_a = SEED; mdl_b = SEED; end
    else begin
      if (sel[0]) mdl_a = pa;
      if (sel[1]) mdl_b = pb;
    end
    exp_sig = (sel[0] ? ma : 16'h0) ^ (sel[1] ? mb : 16'h0); // R4 R5 R6
    reg_rd(8'h24, lo);
    reg_rd(8'h25, hi);
    chk(sel == 2'b11 || sel == 2'b00 ? "R6" : "R5", 32'(lo), 32'(exp_sig[7:0]), {name, " result low"});
    chk(sel == 2'b11 || sel == 2'b00 ? "R6" : "R5", 32'(hi), 32'(exp_sig[15:8]), {name, " result high"});
    reg_rd(8'h0E, cr);
    chk(poke ? "R9" : "R7", 32'(cr), 32'({5'b0, keep, sel}), {name, " control readback"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R10", 32'(busy), 32'd0, "busy in reset");
    chk("R10", 32'(done), 32'd0, "done in reset");
    chk("R10", 32'(dout_a), 32'd0, "dout A in reset");
    chk("R10", 32'(dout_b), 32'd0, "dout B in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 32'(dout_a), 32'(adc_a), "idle pass-through A");
    chk("R1", 32'(dout_b), 32'(adc_b), "idle pass-through B");
    reg_rd(8'h24, v); chk("R10", 32'(v), 32'd0, "result low after reset");
    reg_rd(8'h25, v); chk("R10", 32'(v), 32'd0, "result high after reset");
    reg_rd(8'h0E, v); chk("R10", 32'(v), 32'd0, "control after reset");
    reg_rd(8'h33, v); chk("R11", 32'(v), 32'd0, "unmapped read");

    run_case(2'b01, 1'b0, 1'b0, "A reseed");
    run_case(2'b10, 1'b0, 1'b0, "B reseed");
    run_case(2'b11, 1'b0, 1'b0, "both reseed");
    run_case(2'b01, 1'b1, 1'b0, "A resume");
    run_case(2'b11, 1'b1, 1'b0, "both resume");
    run_case(2'b00, 1'b0, 1'b0, "none");

    reg_wr(8'h0D, 8'h10);
    reg_rd(8'h0D, v); chk("R8", 32'(v), 32'h10, "test register readback");
    mdl_hold = 1'b1;
    run_case(2'b01, 1'b1, 1'b0, "A held");
    reg_wr(8'h0D, 8'h00);
    mdl_hold = 1'b0;

    run_case(2'b01, 1'b0, 1'b1, "A with busy write");
    run_case(2'b10, 1'b1, 1'b0, "B resume after hold");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule